// File: doc/BRIEF.md
# Dual-Plane Program/Erase Status Generator

This block decides what a read returns while a flash array is busy with an embedded program or erase. Each plane keeps its own record of what it is doing: a running program along with the byte being written, a running erase along with the sector being erased (or the whole plane, for a chip-wide erase), and whether that erase is currently held in suspension. On every read strobe the block looks at the addressed plane and the addressed sector. It then either raises a pass-through flag, so the surrounding logic returns true array contents, or supplies an 8-bit status byte built from the polling, toggle and auxiliary toggle bits.

The two planes are independent. A plane with no operation in progress always passes array data, even while the other plane is busy. Each plane keeps its own pair of toggle flip-flops, and both are cleared when an operation starts on that plane. The block also drives an open-drain style ready/busy indication: a pull-low enable that is active while any plane is programming, or is erasing without being suspended.

The response is registered. It appears on the clock edge that samples the read strobe. Array storage and the command decoder sit outside this block.

Top module: `stsgen_top`

## Requirements
- R1: A read from a plane with no program and no erase in progress gives `rsp_array` = 1 and `rsp_status` = 0.
- R2: While a plane is programming, a read of that plane gives status bit 7 equal to the inverse of bit 7 of the byte being programmed.
- R3: While a plane is erasing and the erase is not suspended, a read of that plane gives status bit 7 = 0.
- R4: Status bit 6 starts at 0 after an operation starts. It inverts on each read of a programming or an actively erasing plane. Once that operation's done event arrives, reads of the plane return array data again.
- R5: Status bit 2 toggles on reads of an erasing plane. It reads 1 on reads of a plane that is programming with no erase pending.
- R6: While a plane's erase is suspended, a read of the erasing sector gives bit 7 = 1, bit 6 = 1 and a toggling bit 2, starting at 0. A read of any other sector in that plane gives array data. When the erase covers the whole plane, every sector counts as the erasing sector.
- R7: While an erase is suspended and a program runs in the same plane, reads of that plane give the inverted bit 7, a toggling bit 6 and a toggling bit 2.
- R8: `busy_pull_low` is 1 exactly when some plane is programming, or is erasing without suspension. A suspended erase alone releases it.
- R9: `rsp_valid` is 1 in the cycle after a read strobe and 0 otherwise. Status bits 5, 4, 3, 1 and 0 are always 0.
- R10: The toggle state and operation state of each plane are independent. Starting an operation on one plane does not reset the other plane's toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_plane | input | PW | Plane index of the read |
| rd_sector | input | SECT_W | Sector index within the plane for the read |
| prog_start | input | 1 | Program begins on `prog_plane` |
| prog_done | input | 1 | Program on `prog_plane` has completed |
| prog_plane | input | PW | Plane targeted by the program events |
| prog_data | input | 8 | Byte being programmed, captured at start |
| erase_start_mask | input | N_PLANES | Erase begins on each plane whose bit is set |
| erase_done_mask | input | N_PLANES | Erase ends on each plane whose bit is set |
| erase_whole | input | 1 | The starting erase covers the whole plane |
| erase_sector | input | SECT_W | Sector being erased, captured at start |
| erase_susp | input | N_PLANES | Per-plane level: the erase is held suspended |
| rsp_valid | output | 1 | Response registered for the previous read |
| rsp_array | output | 1 | Return array data for the previous read |
| rsp_status | output | 8 | Status byte (bit 7 polling, bit 6 toggle, bit 2 auxiliary toggle) |
| busy_pull_low | output | 1 | Enable for the open-drain pull-down of the ready/busy line |

## Verification
The bench uses the default build: two planes and a 4-bit sector index. With these values every sector of a plane can be swept during a suspended erase, and all 256 program bytes can be driven on both planes. That covers the polling inversion for every byte value and the hit/miss decision for every sector. Long runs of reads check the toggle phase after each start, stop and resume. Concurrent program and erase on the two planes show that the toggle state of one plane is untouched by events on the other.

// File: rtl/stsgen_pkg.sv
package stsgen_pkg;

  localparam int STAT_W  = 8;
  localparam int POLL_B  = 7;
  localparam int TOG_B   = 6;
  localparam int AUX_B   = 2;

  typedef enum logic [1:0] {
    RK_ARRAY    = 2'd0,
    RK_PROG     = 2'd1,
    RK_ERASE    = 2'd2,
    RK_SUSP_HIT = 2'd3
  } rd_kind_e;

  // Classify a read of one plane from its operation state.
  function automatic rd_kind_e classify(logic prog_on, logic erase_on,
                                        logic susp_now, logic sect_hit);
    rd_kind_e k;
    if (prog_on)                    k = RK_PROG;
    else if (erase_on && !susp_now) k = RK_ERASE;
    else if (susp_now && sect_hit)  k = RK_SUSP_HIT;
    else                            k = RK_ARRAY;
    return k;
  endfunction

  // Assemble the status byte; unused positions stay zero.
  function automatic logic [STAT_W-1:0] build_status(rd_kind_e k, logic d7,
                                                     logic t6, logic t2,
                                                     logic erase_pend);
    logic [STAT_W-1:0] s;
    s = '0;
    unique case (k)
      RK_PROG: begin
        s[POLL_B] = ~d7;
        s[TOG_B]  = t6;
        s[AUX_B]  = erase_pend ? t2 : 1'b1;
      end
      RK_ERASE: begin
        s[POLL_B] = 1'b0;
        s[TOG_B]  = t6;
        s[AUX_B]  = t2;
      end
      RK_SUSP_HIT: begin
        s[POLL_B] = 1'b1;
        s[TOG_B]  = 1'b1;
        s[AUX_B]  = t2;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic flips_main(rd_kind_e k);
    return (k == RK_PROG) || (k == RK_ERASE);
  endfunction

  function automatic logic flips_aux(rd_kind_e k, logic erase_pend);
    return (k == RK_ERASE) || (k == RK_SUSP_HIT) ||
           ((k == RK_PROG) && erase_pend);
  endfunction

endpackage

// File: rtl/stsgen_plane.sv
module stsgen_plane
  import stsgen_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_prog_go,
  input  logic                op_prog_end,
  input  logic [STAT_W-1:0]   prog_byte,
  input  logic                op_erase_go,
  input  logic                op_erase_end,
  input  logic                erase_whole_in,
  input  logic [SECT_W-1:0]   erase_sect_in,
  input  logic                susp_lvl,
  input  logic                rd_go,
  input  logic [SECT_W-1:0]   rd_sect,
  output logic                plane_busy,
  output rd_kind_e            kind_o,
  output logic [STAT_W-1:0]   stat_o
);

  logic              prog_on, erase_on, whole_q;
  logic [SECT_W-1:0] sect_q;
  logic              d7_q, t6_q, t2_q;

  // Named internal events
  logic susp_now, sect_hit, any_start, flip6, flip2;

  assign susp_now  = erase_on & susp_lvl;
  assign sect_hit  = whole_q | (rd_sect == sect_q);
  assign any_start = op_prog_go | op_erase_go;
  assign kind_o    = classify(prog_on, erase_on, susp_now, sect_hit);
  assign flip6     = rd_go & flips_main(kind_o);
  assign flip2     = rd_go & flips_aux(kind_o, erase_on);
  assign stat_o    = build_status(kind_o, d7_q, t6_q, t2_q, erase_on);
  assign plane_busy = prog_on | (erase_on & ~susp_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_on  <= 1'b0;
      d7_q     <= 1'b0;
    end else if (op_prog_go) begin
      prog_on  <= 1'b1;
      d7_q     <= prog_byte[POLL_B];
    end else if (op_prog_end) begin
      prog_on  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_on <= 1'b0;
      whole_q  <= 1'b0;
      sect_q   <= '0;
    end else if (op_erase_go) begin
      erase_on <= 1'b1;
      whole_q  <= erase_whole_in;
      sect_q   <= erase_sect_in;
    end else if (op_erase_end) begin
      erase_on <= 1'b0;
      whole_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (any_start) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      if (flip6) t6_q <= ~t6_q;
      if (flip2) t2_q <= ~t2_q;
    end
  end

endmodule

// File: rtl/stsgen_sel.sv
module stsgen_sel
  import stsgen_pkg::*;
#(
  parameter int N_PLANES = 2,
  parameter int PW       = 1
) (
  input  logic [PW-1:0]                   sel,
  input  rd_kind_e                        kind_i [N_PLANES],
  input  logic [N_PLANES-1:0][STAT_W-1:0] stat_i,
  output logic                            arr_o,
  output logic [STAT_W-1:0]               stat_o
);

  // A plane index beyond the populated range reads as array data.
  always_comb begin
    arr_o  = 1'b1;
    stat_o = '0;
    for (int i = 0; i < N_PLANES; i++) begin
      if (sel == PW'(i)) begin
        arr_o  = (kind_i[i] == RK_ARRAY);
        stat_o = stat_i[i];
      end
    end
  end

endmodule

// File: rtl/stsgen_top.sv
module stsgen_top
  import stsgen_pkg::*;
#(
  parameter int N_PLANES = 2,
  parameter int SECT_W   = 4,
  localparam int PW      = (N_PLANES > 1) ? $clog2(N_PLANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic [PW-1:0]       rd_plane,
  input  logic [SECT_W-1:0]   rd_sector,
  input  logic                prog_start,
  input  logic                prog_done,
  input  logic [PW-1:0]       prog_plane,
  input  logic [7:0]          prog_data,
  input  logic [N_PLANES-1:0] erase_start_mask,
  input  logic [N_PLANES-1:0] erase_done_mask,
  input  logic                erase_whole,
  input  logic [SECT_W-1:0]   erase_sector,
  input  logic [N_PLANES-1:0] erase_susp,
  output logic                rsp_valid,
  output logic                rsp_array,
  output logic [7:0]          rsp_status,
  output logic                busy_pull_low
);

  logic [N_PLANES-1:0]             plane_busy_w;
  rd_kind_e                        kind_w [N_PLANES];
  logic [N_PLANES-1:0][STAT_W-1:0] stat_w;
  logic                            sel_arr;
  logic [STAT_W-1:0]               sel_stat;

  for (genvar g = 0; g < N_PLANES; g++) begin : g_plane
    logic here_prog, here_rd;
    assign here_prog = (prog_plane == PW'(g));
    assign here_rd   = rd_stb && (rd_plane == PW'(g));

    stsgen_plane #(.SECT_W(SECT_W)) u_plane (
      .clk            (clk),
      .rst_n          (rst_n),
      .op_prog_go     (prog_start & here_prog),
      .op_prog_end    (prog_done & here_prog),
      .prog_byte      (prog_data),
      .op_erase_go    (erase_start_mask[g]),
      .op_erase_end   (erase_done_mask[g]),
      .erase_whole_in (erase_whole),
      .erase_sect_in  (erase_sector),
      .susp_lvl       (erase_susp[g]),
      .rd_go          (here_rd),
      .rd_sect        (rd_sector),
      .plane_busy     (plane_busy_w[g]),
      .kind_o         (kind_w[g]),
      .stat_o         (stat_w[g])
    );
  end

  stsgen_sel #(.N_PLANES(N_PLANES), .PW(PW)) u_sel (
    .sel    (rd_plane),
    .kind_i (kind_w),
    .stat_i (stat_w),
    .arr_o  (sel_arr),
    .stat_o (sel_stat)
  );

  assign busy_pull_low = |plane_busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_array  <= 1'b0;
      rsp_status <= '0;
    end else begin
      rsp_valid <= rd_stb;
      if (rd_stb) begin
        rsp_array  <= sel_arr;
        rsp_status <= sel_stat;
      end
    end
  end

endmodule

// File: rtl/stsgen_chk.sv
module stsgen_chk #(
  parameter int N_PLANES = 2,
  parameter int SECT_W   = 4,
  parameter int PW       = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_stb,
  input logic                prog_start,
  input logic [N_PLANES-1:0] erase_start_mask,
  input logic [N_PLANES-1:0] erase_susp,
  input logic                rsp_valid,
  input logic                rsp_array,
  input logic [7:0]          rsp_status,
  input logic                busy_pull_low
);

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rsp_valid);

  assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rsp_valid);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_status & 8'h3B) == 8'h00));

  assert_array_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_array) |-> (rsp_status == 8'h00));

  assert_prog_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy_pull_low);

  assert_erase_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|erase_start_mask) |=> (busy_pull_low || (|erase_susp)));

endmodule

bind stsgen_top stsgen_chk #(
  .N_PLANES(N_PLANES), .SECT_W(SECT_W), .PW(PW)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rd_stb           (rd_stb),
  .prog_start       (prog_start),
  .erase_start_mask (erase_start_mask),
  .erase_susp       (erase_susp),
  .rsp_valid        (rsp_valid),
  .rsp_array        (rsp_array),
  .rsp_status       (rsp_status),
  .busy_pull_low    (busy_pull_low)
);

// File: tb/sim_stsgen_top.sv
module sim_stsgen_top;

  localparam int NP = 2;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [0:0]    rd_plane = '0;
  logic [SW-1:0] rd_sector = '0;
  logic          prog_start = 1'b0, prog_done = 1'b0;
  logic [0:0]    prog_plane = '0;
  logic [7:0]    prog_data = '0;
  logic [NP-1:0] erase_start_mask = '0, erase_done_mask = '0, erase_susp = '0;
  logic          erase_whole = 1'b0;
  logic [SW-1:0] erase_sector = '0;
  logic          rsp_valid, rsp_array, busy_pull_low;
  logic [7:0]    rsp_status;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  stsgen_top #(.N_PLANES(NP), .SECT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_plane(rd_plane),
    .rd_sector(rd_sector), .prog_start(prog_start), .prog_done(prog_done),
    .prog_plane(prog_plane), .prog_data(prog_data),
    .erase_start_mask(erase_start_mask), .erase_done_mask(erase_done_mask),
    .erase_whole(erase_whole), .erase_sector(erase_sector),
    .erase_susp(erase_susp), .rsp_valid(rsp_valid), .rsp_array(rsp_array),
    .rsp_status(rsp_status), .busy_pull_low(busy_pull_low)
  );

  // Bench-side view of each plane
  bit       m_prog [NP];
  bit       m_erase[NP];
  bit       m_whole[NP];
  int       m_sect [NP];
  bit [7:0] m_data [NP];
  bit       m_t6   [NP];
  bit       m_t2   [NP];

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic clr_toggles(int p);
    m_t6[p] = 1'b0;
    m_t2[p] = 1'b0;
  endtask

  task automatic do_read(int p, int s, string req);
    bit       arr;
    bit [7:0] st;
    arr = 1'b0;
    st  = 8'h00;
    if (m_prog[p]) begin
      st[7] = ~m_data[p][7];
      st[6] = m_t6[p];
      st[2] = m_erase[p] ? m_t2[p] : 1'b1;
      m_t6[p] = ~m_t6[p];
      if (m_erase[p]) m_t2[p] = ~m_t2[p];
    end else if (m_erase[p] && !erase_susp[p]) begin
      st[6] = m_t6[p];
      st[2] = m_t2[p];
      m_t6[p] = ~m_t6[p];
      m_t2[p] = ~m_t2[p];
    end else if (m_erase[p] && (m_whole[p] || s == m_sect[p])) begin
      st[7] = 1'b1;
      st[6] = 1'b1;
      st[2] = m_t2[p];
      m_t2[p] = ~m_t2[p];
    end else begin
      arr = 1'b1;
    end
    @(negedge clk);
    rd_stb    = 1'b1;
    rd_plane  = 1'(p);
    rd_sector = SW'(s);
    @(negedge clk);
    rd_stb = 1'b0;
    chk(req, {6'd0, rsp_valid, rsp_array, rsp_status}, {6'd0, 1'b1, arr, st});
  endtask

  task automatic chk_busy(string req);
    bit b;
    b = 1'b0;
    for (int p = 0; p < NP; p++)
      if (m_prog[p] || (m_erase[p] && !erase_susp[p])) b = 1'b1;
    chk(req, {15'd0, busy_pull_low}, {15'd0, b});
  endtask

  task automatic start_prog(int p, bit [7:0] d);
    @(negedge clk);
    prog_start = 1'b1; prog_plane = 1'(p); prog_data = d;
    @(negedge clk);
    prog_start = 1'b0;
    m_prog[p] = 1'b1; m_data[p] = d; clr_toggles(p);
  endtask

  task automatic end_prog(int p);
    @(negedge clk);
    prog_done = 1'b1; prog_plane = 1'(p);
    @(negedge clk);
    prog_done = 1'b0;
    m_prog[p] = 1'b0;
  endtask

  task automatic start_erase(bit [NP-1:0] mask, bit whole, int s);
    @(negedge clk);
    erase_start_mask = mask; erase_whole = whole; erase_sector = SW'(s);
    @(negedge clk);
    erase_start_mask = '0;
    for (int p = 0; p < NP; p++)
      if (mask[p]) begin
        m_erase[p] = 1'b1; m_whole[p] = whole; m_sect[p] = s; clr_toggles(p);
      end
  endtask

  task automatic end_erase(bit [NP-1:0] mask);
    @(negedge clk);
    erase_done_mask = mask;
    @(negedge clk);
    erase_done_mask = '0;
    for (int p = 0; p < NP; p++) if (mask[p]) m_erase[p] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_prog[p] = 0; m_erase[p] = 0; m_whole[p] = 0; m_sect[p] = 0;
      m_data[p] = 0; clr_toggles(p);
    end
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {15'd0, rsp_valid}, 16'd0);
    chk("R8 reset busy", {15'd0, busy_pull_low}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle planes, every sector
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < (1 << SW); s++) do_read(p, s, "R1 idle");

    // R2/R4/R5/R8: all program bytes on both planes
    for (int d = 0; d < 256; d++)
      for (int p = 0; p < NP; p++) begin
        start_prog(p, 8'(d));
        chk_busy("R8 program busy");
        do_read(p, d % 16, "R2 R4 R5 program read 1");
        do_read(p, 0, "R2 R4 R5 program read 2");
        do_read(1 - p, 3, "R1 other plane idle");
        do_read(p, 7, "R4 program read 3");
        end_prog(p);
        chk_busy("R8 program released");
        do_read(p, 1, "R4 stops after done");
      end

    // R3/R5/R6/R7: sector erase, suspend, program under suspend, resume
    for (int p = 0; p < NP; p++) begin
      start_erase(NP'(1 << p), 1'b0, 5 + p);
      chk_busy("R8 erase busy");
      for (int k = 0; k < 4; k++) do_read(p, k, "R3 R5 erase read");
      do_read(1 - p, 5, "R1 erase other plane");
      @(negedge clk); erase_susp[p] = 1'b1;
      @(negedge clk);
      chk_busy("R8 suspend releases");
      for (int s = 0; s < (1 << SW); s++) do_read(p, s, "R6 suspended sweep");
      do_read(p, 5 + p, "R6 suspended hit again");
      start_prog(p, 8'h3C);
      chk_busy("R8 program under suspend");
      for (int k = 0; k < 3; k++) do_read(p, 9, "R7 program under suspend");
      do_read(p, 5 + p, "R7 read of erasing sector");
      end_prog(p);
      do_read(p, 5 + p, "R6 hit after program");
      do_read(p, 2, "R6 miss after program");
      @(negedge clk); erase_susp[p] = 1'b0;
      @(negedge clk);
      chk_busy("R8 resume busy");
      for (int k = 0; k < 3; k++) do_read(p, k, "R3 R5 resumed erase");
      end_erase(NP'(1 << p));
      do_read(p, 5 + p, "R4 erase done array");
      chk_busy("R8 idle after erase");
    end

    // R6: whole-plane erase on both planes, suspended, every sector hits
    start_erase(2'b11, 1'b1, 0);
    do_read(0, 4, "R3 chip erase plane 0");
    do_read(1, 4, "R3 chip erase plane 1");
    @(negedge clk); erase_susp = 2'b11;
    @(negedge clk);
    chk_busy("R8 both suspended");
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < (1 << SW); s++) do_read(p, s, "R6 whole-plane hit");
    @(negedge clk); erase_susp = 2'b00;
    end_erase(2'b11);

    // R10: concurrent operations keep separate toggles
    start_erase(2'b10, 1'b0, 2);
    do_read(1, 0, "R10 plane 1 erase");
    start_prog(0, 8'h80);
    do_read(1, 0, "R10 plane 1 unaffected by plane 0 start");
    do_read(0, 0, "R10 plane 0 program");
    do_read(0, 0, "R10 plane 0 program again");
    do_read(1, 0, "R10 plane 1 phase kept");
    end_prog(0);
    do_read(0, 0, "R10 plane 0 done");
    do_read(1, 0, "R10 plane 1 still erasing");
    end_erase(2'b10);
    chk_busy("R8 all idle");

    summary();
    $finish;
  end

endmodule